// File: doc/BRIEF.md
# Fault-Abort Register Lockout Controller

This block holds a small bank of configuration registers behind a simple synchronous command port, and guards it against a fault input such as a transient power-loss flag. When the fault input is seen to rise, the block stops normal operation. It returns every configuration register to its reset value, sets an abort flag in its status register and raises a level interrupt.

While the abort flag is set, the block accepts no command that could change state, with one exception: a write of any value to the revision register. The revision register is read-only and holds a fixed constant. Writing to it serves only as the unlock key. It clears the abort flag, and the host may then reprogram the configuration registers.

The register map uses 8-bit addresses and 8-bit data. STATUS is at address 0x00, the revision register is at 0x01, and the configuration registers start at 0x04.

Top module: `fault_lockout_regs`

## Requirements
- R1: After reset, all configuration registers read 0, STATUS reads 0x00 and irq is low.
- R2: When abort is clear, a write to configuration address 0x04..0x07 takes effect on the next clock edge. A read returns the register value on rd_data one cycle after the read command. Unmapped addresses read 0.
- R3: fault_in passes through a two-flop synchronizer. Its rising edge takes effect on the third clock edge after fault_in rises. At that edge all configuration registers return to 0, STATUS bit 0 (abort) and bit 1 (interrupt pending) are set, and irq goes high.
- R4: While abort is set, writes to configuration registers are discarded.
- R5: While abort is set, reads of configuration registers return 0. Reads of STATUS and of the revision register return their true values.
- R6: A write of any value to the revision register (0x01) clears abort. The revision register keeps reading its constant 0x41.
- R7: Outside abort, a write to the revision register has no effect on any register or on irq.
- R8: irq stays high until STATUS is read. The STATUS read returns the value held before the read, and clears the pending bit on the next edge.
- R9: If a fault edge and a STATUS read occur in the same cycle, the pending bit stays set and irq stays high.
- R10: A fault input that is still held after abort is cleared does not start a new abort. A new abort needs fault_in to deassert and then assert again.
- R11: Writes to STATUS are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_in | input | 1 | Asynchronous fault flag |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 8 | Register address |
| cmd_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid one cycle after a read |
| irq | output | 1 | Level interrupt, follows the pending bit |
| cfg_out | output | 32 | Configuration register contents, register 0 in the low byte |

## Verification
The assertions take for granted that at most one command is presented per cycle. They also assume that fault_in changes only while no command is in flight, except where a test deliberately lines up a fault edge with a STATUS read. The bench drives every input at the falling clock edge and holds each command for exactly one cycle. It schedules fault edges by counting the synchronizer stages, so that the coincidence case of R9 lands in a known cycle.

// File: rtl/fault_lockout_regs.sv
module fault_lockout_regs #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int NCFG = 4,
  parameter logic [AW-1:0] CFG_BASE = 8'h04,
  parameter logic [DW-1:0] REV_VALUE = 8'h41,
  parameter logic [DW-1:0] CFG_RST = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_in,
  input  logic cmd_valid,
  input  logic cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic [DW-1:0] rd_data,
  output logic irq,
  output logic [NCFG*DW-1:0] cfg_out
);
  localparam logic [AW-1:0] ADDR_STATUS = '0;
  localparam logic [AW-1:0] ADDR_REV = AW'(1);

  logic [2:0] sync;
  logic abt, pend;
  logic [DW-1:0] cfg [NCFG];
  logic [DW-1:0] rd_val;
  logic [DW-1:0] status_val;

  wire fault_edge = sync[1] & ~sync[2];
  wire is_rd = cmd_valid & ~cmd_write;
  wire is_wr = cmd_valid & cmd_write;
  wire rev_wr = is_wr && cmd_addr == ADDR_REV;
  wire st_rd = is_rd && cmd_addr == ADDR_STATUS;

  assign status_val = {{(DW-2){1'b0}}, pend, abt};
  assign irq = pend;

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= '0;
    else sync <= {sync[1:0], fault_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abt <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (fault_edge) abt <= 1'b1;
      else if (rev_wr) abt <= 1'b0;
      if (fault_edge) pend <= 1'b1;
      else if (st_rd) pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NCFG; i++) begin
      if (!rst_n || fault_edge) cfg[i] <= CFG_RST;
      else if (is_wr && !abt && cmd_addr == CFG_BASE + AW'(i)) cfg[i] <= cmd_wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    if (cmd_addr == ADDR_STATUS) rd_val = status_val;
    else if (cmd_addr == ADDR_REV) rd_val = REV_VALUE;
    else if (!abt)
      for (int i = 0; i < NCFG; i++)
        if (cmd_addr == CFG_BASE + AW'(i)) rd_val = cfg[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (is_rd) rd_data <= rd_val;
  end

  for (genvar g = 0; g < NCFG; g++) begin : g_out
    assign cfg_out[g*DW +: DW] = cfg[g];
  end
endmodule

// File: rtl/fault_lockout_chk.sv
module fault_lockout_chk #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int NCFG = 4,
  parameter logic [AW-1:0] CFG_BASE = 8'h04
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_write,
  input logic [AW-1:0] cmd_addr,
  input logic [DW-1:0] rd_data,
  input logic irq,
  input logic [NCFG*DW-1:0] cfg_out,
  input logic abt,
  input logic fault_edge
);
  wire st_rd = cmd_valid && !cmd_write && cmd_addr == '0;
  wire cfg_hit = cmd_addr >= CFG_BASE && cmd_addr < CFG_BASE + AW'(NCFG);

  p_fault_abt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_edge |=> abt && irq && cfg_out == '0);
  p_cfg_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (abt && cmd_valid && cmd_write && !fault_edge) |=> $stable(cfg_out));
  p_lock_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (abt && cmd_valid && !cmd_write && cfg_hit) |=> rd_data == '0);
  p_rev_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (abt && cmd_valid && cmd_write && cmd_addr == AW'(1) && !fault_edge) |=> !abt);
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !st_rd) |=> irq);
  p_irq_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_edge && st_rd) |=> irq);
endmodule

bind fault_lockout_regs fault_lockout_chk #(.AW(AW), .DW(DW), .NCFG(NCFG), .CFG_BASE(CFG_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
  .cmd_addr(cmd_addr), .rd_data(rd_data), .irq(irq), .cfg_out(cfg_out),
  .abt(abt), .fault_edge(fault_edge));

// File: tb/tb_fault_lockout_regs.sv
module tb_fault_lockout_regs;
  logic clk = 0, rst_n = 0, fault_in = 0, cmd_valid = 0, cmd_write = 0;
  logic [7:0] cmd_addr = 0, cmd_wdata = 0;
  logic [7:0] rd_data;
  logic irq;
  logic [31:0] cfg_out;
  int total = 0, bad = 0;

  fault_lockout_regs dut (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_write = 1; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 0; cmd_write = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_write = 0; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 0;
    d = rd_data;
  endtask

  task automatic raise_fault();
    @(negedge clk); fault_in = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 cfg", cfg_out, 0);
    chk("R1 irq", irq, 0);
    rd(8'h00, d); chk("R1 status", d, 8'h00);
  endtask

  task automatic t_rw();
    logic [7:0] d;
    wr(8'h04, 8'h11); wr(8'h05, 8'h22); wr(8'h06, 8'h33); wr(8'h07, 8'hC4);
    chk("R2 cfg_out", cfg_out, 32'hC4332211);
    rd(8'h06, d); chk("R2 read", d, 8'h33);
    rd(8'h20, d); chk("R2 unmapped", d, 8'h00);
    wr(8'h00, 8'hFF); rd(8'h00, d); chk("R11 status write", d, 8'h00);
    chk("R11 irq", irq, 0);
    wr(8'h01, 8'h5A); chk("R7 cfg", cfg_out, 32'hC4332211);
    rd(8'h01, d); chk("R7 rev", d, 8'h41);
    chk("R7 irq", irq, 0);
  endtask

  task automatic t_fault();
    logic [7:0] d;
    @(negedge clk); fault_in = 1;
    @(negedge clk); @(negedge clk);
    chk("R3 before edge3", irq, 0);
    @(negedge clk);
    chk("R3 irq", irq, 1);
    chk("R3 cfg reset", cfg_out, 0);
    wr(8'h05, 8'h77); chk("R4 locked", cfg_out, 0);
    rd(8'h05, d); chk("R5 cfg rd", d, 8'h00);
    rd(8'h01, d); chk("R5 rev rd", d, 8'h41);
    repeat (3) @(negedge clk);
    chk("R8 irq held", irq, 1);
    rd(8'h00, d); chk("R8 status", d, 8'h03);
    chk("R8 irq clear", irq, 0);
    rd(8'h00, d); chk("R5 status abt", d, 8'h01);
    wr(8'h01, 8'h00);
    rd(8'h00, d); chk("R6 abt clear", d, 8'h00);
    rd(8'h01, d); chk("R6 rev kept", d, 8'h41);
    wr(8'h04, 8'h9E); chk("R6 reinit", cfg_out, 32'h0000009E);
  endtask

  task automatic t_held();
    logic [7:0] d;
    repeat (6) @(negedge clk);
    rd(8'h00, d); chk("R10 held no abort", d, 8'h00);
    chk("R10 cfg", cfg_out, 32'h0000009E);
    @(negedge clk); fault_in = 0;
    repeat (4) @(negedge clk);
    raise_fault();
    chk("R10 re-abort irq", irq, 1);
    chk("R10 re-abort cfg", cfg_out, 0);
    wr(8'h01, 8'hFF);
    rd(8'h00, d); chk("R10 status", d, 8'h02);
    rd(8'h00, d);
    chk("R10 cleared", irq, 0);
  endtask

  task automatic t_coincide();
    logic [7:0] d;
    @(negedge clk); fault_in = 0;
    repeat (4) @(negedge clk);
    fault_in = 1;
    @(negedge clk); @(negedge clk);
    cmd_valid = 1; cmd_write = 0; cmd_addr = 8'h00;
    @(negedge clk);
    cmd_valid = 0;
    chk("R9 read value", rd_data, 8'h00);
    chk("R9 irq kept", irq, 1);
    rd(8'h00, d); chk("R9 status", d, 8'h03);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_rw();
    t_fault();
    t_held();
    t_coincide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule